// File: doc/BRIEF.md
# Linked-List Scatter-Gather Read DMA

This engine walks a null-terminated chain of descriptors in system memory and streams out the data each descriptor points at. Software first puts the 64-bit physical address of the first descriptor into the base registers. It then writes the start bit. The engine fetches one descriptor at a time over a single-outstanding memory-read request/response port. It checks the descriptor's fields, reads the segment in 32-bit beats and presents them on a valid/ready output stream. It then follows the next pointer. A next pointer of zero ends the walk. A single interrupt is raised once every beat of the chain has left the stream, not once per descriptor.

Each descriptor occupies 24 bytes. The segment address (64 bits) sits at byte offset 0, the segment length in bytes (32 bits) at offset 8, and the next pointer (64 bits) at offset 16. The word at offset 12 is padding and is never read. The block handles the read direction only.

Back-pressure rules: once `st_valid` is high, `st_data` and `st_last` hold until `st_ready` is seen high at a clock edge. While a beat is held, the engine issues no memory request of any kind. A beat is transferred on each edge where `st_valid` and `st_ready` are both high.

Top module: `sg_chain_dma`

## Requirements
- R1: After reset the status register reads 0, `irq` is low, `st_valid` is low and `mrd_req_valid` is low.
- R2: Each descriptor is fetched as five 32-bit reads, in the order: descriptor address plus 0, 4, 8, 16, 20. The first descriptor address is {base_hi, base_lo}, and all request addresses are 4-byte aligned.
- R3: A segment of length L is read as ceil(L/4) beats at consecutive addresses, starting at the segment address and rising by 4. Each response word appears on `st_data` in request order.
- R4: `st_last` is 1 on the final beat of each segment and 0 on every other beat.
- R5: A beat offered with `st_ready` low holds its data until it is taken. No memory request is made while `st_valid` is 1 and `st_ready` is 0.
- R6: The walk ends after the segment of the descriptor whose next pointer is 0. Done (and `irq`) rises only after the last beat of the chain has been accepted.
- R7: `irq` equals the done bit. Writing 1 to status bit 1 clears done, and writing 1 to status bit 2 clears error.
- R8: A start write while the engine is busy has no effect on the request sequence or on the stream.
- R9: A descriptor with length 0 issues no segment reads, and the walk continues to its next pointer.
- R10: Any of the following aborts the walk with the error bit and the done bit both set: a base or next pointer not 4-byte aligned, a segment address not 4-byte aligned, or a length above 4096. No read is issued for the faulty descriptor's segment or beyond it. A length of exactly 4096 is accepted.
- R11: Register select 0 is base_lo, 1 is base_hi, 2 is control (bit 0 = start), and 3 is status (bit 0 busy, bit 1 done, bit 2 error). Busy reads 1 during a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_sel | input | 2 | register select |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data for reg_sel |
| irq | output | 1 | completion interrupt (follows done) |
| mrd_req_valid | output | 1 | memory read request valid |
| mrd_req_ready | input | 1 | memory read request accepted |
| mrd_req_addr | output | 64 | read byte address |
| mrd_rsp_valid | input | 1 | read response valid, one per request |
| mrd_rsp_data | input | 32 | read response word |
| st_valid | output | 1 | stream beat valid |
| st_ready | input | 1 | stream consumer ready |
| st_data | output | 32 | stream beat data |
| st_last | output | 1 | final beat of a segment |

## Verification
Two conditions are the hardest to reach. The first is a stream stall that coincides with the engine wanting its next descriptor word. The second is a late abort after some data is already in flight, which must still drain before the interrupt. The stimulus throttles `st_ready` on a fixed pattern across a chain with odd-length and zero-length segments. In parallel, request acceptance and response latency vary each cycle. Error chains place the fault in a later descriptor so that earlier beats are still pending when the fault is found.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  typedef enum logic [2:0] {
    W_IDLE, W_DREQ, W_DWAIT, W_CHECK, W_SREQ, W_SWAIT, W_DRAIN
  } walk_state_t;

  localparam int DESC_WORDS = 5;
  localparam logic [1:0] SEL_BASE_LO = 2'd0;
  localparam logic [1:0] SEL_BASE_HI = 2'd1;
  localparam logic [1:0] SEL_CTRL    = 2'd2;
  localparam logic [1:0] SEL_STATUS  = 2'd3;

  // byte offset of descriptor word idx; the word at offset 12 is padding
  function automatic logic [4:0] word_offset(input logic [2:0] idx);
    logic [4:0] base;
    base = {idx, 2'b00};
    return (idx < 3'd3) ? base : base + 5'd4;
  endfunction
endpackage

// File: rtl/sgd_regs.sv
module sgd_regs import sgd_pkg::*; #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          busy,
  input  logic          fin_valid,
  input  logic          fin_err,
  output logic [63:0]   base,
  output logic          start,
  output logic          done,
  output logic          err
);
  logic clr_done, clr_err;

  assign start    = we && (sel == SEL_CTRL) && wdata[0] && !busy;
  assign clr_done = we && (sel == SEL_STATUS) && wdata[1];
  assign clr_err  = we && (sel == SEL_STATUS) && wdata[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (we && sel == SEL_BASE_LO) base[31:0]  <= wdata[31:0];
      if (we && sel == SEL_BASE_HI) base[63:32] <= wdata[31:0];
      if (fin_valid)     done <= 1'b1;
      else if (clr_done) done <= 1'b0;
      if (fin_valid && fin_err) err <= 1'b1;
      else if (clr_err)         err <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_BASE_LO: rdata = base[31:0];
      SEL_BASE_HI: rdata = base[63:32];
      SEL_STATUS:  rdata = {{(DW-3){1'b0}}, err, done, busy};
      default:     rdata = '0;
    endcase
  end

  // an error never appears without the interrupt
  p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
endmodule

// File: rtl/sgd_stream_buf.sv
module sgd_stream_buf #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          push_last,
  output logic          buf_free,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last
);
  assign buf_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= push_data;
      out_last  <= push_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  p_push_into_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !out_valid);
endmodule

// File: rtl/sgd_walker.sv
module sgd_walker import sgd_pkg::*; #(
  parameter int DW            = 32,
  parameter int MAX_SEG_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [63:0]   base,
  output logic          busy,
  output logic          fin_valid,
  output logic          fin_err,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [63:0]   req_addr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic          buf_free,
  input  logic          out_valid,
  output logic          push,
  output logic [DW-1:0] push_data,
  output logic          push_last
);
  localparam int BEAT_BYTES = DW / 8;
  localparam int MAX_BEATS  = MAX_SEG_BYTES / BEAT_BYTES;
  localparam int BEAT_W     = $clog2(MAX_BEATS) + 1;

  walk_state_t state;
  logic [63:0] cur_desc, seg_addr, next_ptr, beat_addr;
  logic [31:0] seg_len;
  logic [2:0]  widx;
  logic [BEAT_W-1:0] beats_left;
  logic        err_r;
  logic        seg_bad, go_next;
  logic [31:0] beat_total;

  assign busy       = (state != W_IDLE);
  assign seg_bad    = (seg_addr[1:0] != 2'b00) || (seg_len > 32'(MAX_SEG_BYTES));
  assign beat_total = (seg_len + 32'(BEAT_BYTES - 1)) / 32'(BEAT_BYTES);
  assign go_next    = (state == W_CHECK && !seg_bad && seg_len == 32'd0) ||
                      (state == W_SWAIT && rsp_valid && beats_left == BEAT_W'(1));

  assign req_valid = (state == W_DREQ || state == W_SREQ) && buf_free;
  assign req_addr  = (state == W_DREQ) ? cur_desc + 64'(word_offset(widx)) : beat_addr;
  assign push      = (state == W_SWAIT) && rsp_valid;
  assign push_data = rsp_data;
  assign push_last = (beats_left == BEAT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= W_IDLE;
      cur_desc   <= '0;
      seg_addr   <= '0;
      seg_len    <= '0;
      next_ptr   <= '0;
      beat_addr  <= '0;
      beats_left <= '0;
      widx       <= '0;
      err_r      <= 1'b0;
      fin_valid  <= 1'b0;
      fin_err    <= 1'b0;
    end else begin
      fin_valid <= 1'b0;
      fin_err   <= 1'b0;
      case (state)
        W_IDLE: if (start) begin
          cur_desc <= base;
          widx     <= '0;
          err_r    <= (base[1:0] != 2'b00);
          state    <= (base[1:0] != 2'b00) ? W_DRAIN : W_DREQ;
        end
        W_DREQ: if (req_valid && req_ready) state <= W_DWAIT;
        W_DWAIT: if (rsp_valid) begin
          case (widx)
            3'd0:    seg_addr[31:0]  <= rsp_data;
            3'd1:    seg_addr[63:32] <= rsp_data;
            3'd2:    seg_len         <= rsp_data;
            3'd3:    next_ptr[31:0]  <= rsp_data;
            default: next_ptr[63:32] <= rsp_data;
          endcase
          if (widx == 3'(DESC_WORDS - 1)) state <= W_CHECK;
          else begin
            widx  <= widx + 3'd1;
            state <= W_DREQ;
          end
        end
        W_CHECK: if (seg_bad) begin
          err_r <= 1'b1;
          state <= W_DRAIN;
        end else if (seg_len != 32'd0) begin
          beats_left <= beat_total[BEAT_W-1:0];
          beat_addr  <= seg_addr;
          state      <= W_SREQ;
        end
        W_SREQ: if (req_valid && req_ready) state <= W_SWAIT;
        W_SWAIT: if (rsp_valid) begin
          beats_left <= beats_left - BEAT_W'(1);
          beat_addr  <= beat_addr + 64'(BEAT_BYTES);
          state      <= W_SREQ;
        end
        W_DRAIN: if (!out_valid) begin
          fin_valid <= 1'b1;
          fin_err   <= err_r;
          state     <= W_IDLE;
        end
        default: state <= W_IDLE;
      endcase
      if (go_next) begin
        if (next_ptr == 64'd0) state <= W_DRAIN;
        else if (next_ptr[1:0] != 2'b00) begin
          err_r <= 1'b1;
          state <= W_DRAIN;
        end else begin
          cur_desc <= next_ptr;
          widx     <= '0;
          state    <= W_DREQ;
        end
      end
    end
  end

  p_req_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[1:0] == 2'b00);
  p_beats_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state == W_SREQ |-> beats_left != '0 && beats_left <= BEAT_W'(MAX_BEATS));
  p_finish_drained_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_valid |-> !out_valid);
  p_no_req_when_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !buf_free |-> !req_valid);
endmodule

// File: rtl/sg_chain_dma.sv
module sg_chain_dma #(
  parameter int DW            = 32,
  parameter int MAX_SEG_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          mrd_req_valid,
  input  logic          mrd_req_ready,
  output logic [63:0]   mrd_req_addr,
  input  logic          mrd_rsp_valid,
  input  logic [DW-1:0] mrd_rsp_data,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [DW-1:0] st_data,
  output logic          st_last
);
  logic [63:0]   base;
  logic          start, busy, fin_valid, fin_err, done, err;
  logic          buf_free, push, push_last;
  logic [DW-1:0] push_data;

  sgd_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .fin_valid(fin_valid), .fin_err(fin_err),
    .base(base), .start(start), .done(done), .err(err)
  );

  sgd_walker #(.DW(DW), .MAX_SEG_BYTES(MAX_SEG_BYTES)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .busy(busy),
    .fin_valid(fin_valid), .fin_err(fin_err),
    .req_valid(mrd_req_valid), .req_ready(mrd_req_ready), .req_addr(mrd_req_addr),
    .rsp_valid(mrd_rsp_valid), .rsp_data(mrd_rsp_data),
    .buf_free(buf_free), .out_valid(st_valid),
    .push(push), .push_data(push_data), .push_last(push_last)
  );

  sgd_stream_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .push_last(push_last), .buf_free(buf_free), .out_valid(st_valid),
    .out_ready(st_ready), .out_data(st_data), .out_last(st_last)
  );

  assign irq = done;

  p_done_only_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);
endmodule

// File: tb/sg_chain_dma_test.sv
module sg_chain_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mrd_req_valid, mrd_req_ready = 1'b0;
  logic [63:0] mrd_req_addr;
  logic        mrd_rsp_valid = 1'b0;
  logic [31:0] mrd_rsp_data = '0;
  logic        st_valid, st_ready = 1'b0, st_last;
  logic [31:0] st_data;

  sg_chain_dma uut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, bp_mode = 0;
  bit finished = 0;
  logic [31:0] mem [logic [63:0]];
  logic [63:0] exp_addr[$];
  logic [32:0] exp_beat[$];
  bit pend_v = 0;
  logic [63:0] pend_a = '0;
  int pend_d = 0;
  bit held = 0;
  logic [32:0] held_val = '0;

  function automatic logic [31:0] rdmem(logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return a[31:0] ^ a[63:32] ^ 32'h5A3C_0000;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(logic [63:0] d, logic [63:0] s, logic [31:0] len, logic [63:0] n);
    mem[d] = s[31:0]; mem[d+4] = s[63:32]; mem[d+8] = len;
    mem[d+12] = 32'hDEAD_BEEF; mem[d+16] = n[31:0]; mem[d+20] = n[63:32];
  endtask

  task automatic exp_desc(logic [63:0] d);
    exp_addr.push_back(d); exp_addr.push_back(d+4); exp_addr.push_back(d+8);
    exp_addr.push_back(d+16); exp_addr.push_back(d+20);
  endtask

  task automatic exp_seg(logic [63:0] s, int len);
    int nb;
    nb = (len + 3) / 4;
    for (int i = 0; i < nb; i++) begin
      exp_addr.push_back(s + 64'(4*i));
      exp_beat.push_back({(i == nb-1), rdmem(s + 64'(4*i))});
    end
  endtask

  // cycle-level memory, stream consumer and comparison against the model
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mrd_rsp_valid = 1'b0;
      if (pend_v) begin
        if (pend_d == 0) begin
          mrd_rsp_valid = 1'b1;
          mrd_rsp_data  = rdmem(pend_a);
          pend_v = 0;
        end else pend_d--;
      end
      st_ready      = (bp_mode == 0) ? 1'b1 : ((cyc % 5) >= 3);
      mrd_req_ready = ((cyc % 3) != 2);
      #1;
      if (rst_n) begin
        if (held) begin
          chk(st_valid && {st_last, st_data} == held_val, "R5 hold", {st_last, st_data}, held_val);
          held = 0;
        end
        if (st_valid && !st_ready) begin
          held = 1; held_val = {st_last, st_data};
          chk(!mrd_req_valid, "R5 no request while held", mrd_req_valid, 0);
        end
        if (st_valid && st_ready) begin
          if (exp_beat.size() == 0) chk(0, "R3 unexpected beat", st_data, 0);
          else begin
            logic [32:0] e;
            e = exp_beat.pop_front();
            chk(st_data == e[31:0], "R3 beat data", st_data, e[31:0]);
            chk(st_last == e[32], "R4 last flag", st_last, e[32]);
          end
        end
        if (mrd_req_valid && mrd_req_ready) begin
          if (exp_addr.size() == 0) chk(0, "R2 unexpected request", mrd_req_addr, 0);
          else begin
            logic [63:0] ea;
            ea = exp_addr.pop_front();
            chk(mrd_req_addr == ea, "R2 request address", mrd_req_addr, ea);
          end
          pend_v = 1; pend_a = mrd_req_addr; pend_d = cyc % 3;
        end
        if (exp_beat.size() != 0 && irq) chk(0, "R6 early irq", irq, 0);
      end
    end
  end

  task automatic reg_write(logic [1:0] s, logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s;
    #2;
    v = reg_rdata;
  endtask

  task automatic start_chain(logic [63:0] b);
    reg_write(2'd0, b[31:0]);
    reg_write(2'd1, b[63:32]);
    reg_write(2'd2, 32'h1);
  endtask

  task automatic finish_chain(bit exp_err, string tag);
    logic [31:0] v;
    int n;
    n = 0;
    while (!irq && n < 20000) begin
      @(negedge clk); n++;
    end
    chk(irq, {tag, " R6 irq raised"}, irq, 1);
    repeat (3) @(negedge clk);
    chk(exp_addr.size() == 0, {tag, " R2 all requests seen"}, exp_addr.size(), 0);
    chk(exp_beat.size() == 0, {tag, " R3 all beats seen"}, exp_beat.size(), 0);
    reg_read(2'd3, v);
    chk(v == {29'd0, exp_err, 1'b1, 1'b0}, {tag, " R11 status after walk"}, v, {29'd0, exp_err, 2'b10});
    reg_write(2'd3, 32'h6);
    reg_read(2'd3, v);
    chk(v == 32'd0 && !irq, {tag, " R7 clear by write-1"}, {irq, v}, 0);
    exp_addr.delete(); exp_beat.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    reg_read(2'd3, v);
    chk(v == 0, "R1 status", v, 0);
    chk(!irq && !st_valid && !mrd_req_valid, "R1 outputs idle", {irq, st_valid, mrd_req_valid}, 0);
    reg_write(2'd1, 32'h0000_0007);
    reg_read(2'd1, v);
    chk(v == 32'h7, "R11 base_hi readback", v, 7);

    // chain of three, odd length in the middle, no back-pressure
    put_desc(64'h1000, 64'h2_0000, 16, 64'h1040);
    put_desc(64'h1040, 64'h2_1000, 10, 64'h1080);
    put_desc(64'h1080, 64'h2_2000, 8, 64'h0);
    exp_desc(64'h1000); exp_seg(64'h2_0000, 16);
    exp_desc(64'h1040); exp_seg(64'h2_1000, 10);
    exp_desc(64'h1080); exp_seg(64'h2_2000, 8);
    start_chain(64'h1000);
    reg_read(2'd3, v);
    chk(v[0], "R11 busy during walk", v, 1);
    finish_chain(0, "three-desc");

    // zero-length descriptor in the middle, heavy back-pressure (R9, R5)
    bp_mode = 1;
    put_desc(64'h3000, 64'h4_0000, 12, 64'h3100);
    put_desc(64'h3100, 64'h4_1000, 0, 64'h3200);
    put_desc(64'h3200, 64'h4_2000, 7, 64'h0);
    exp_desc(64'h3000); exp_seg(64'h4_0000, 12);
    exp_desc(64'h3100);
    exp_desc(64'h3200); exp_seg(64'h4_2000, 7);
    start_chain(64'h3000);
    finish_chain(0, "R9 zero-length");

    // start while busy is ignored (R8), high address via base_hi
    put_desc(64'h5_0000_5000, 64'h5_0006_0000, 64, 64'h0);
    exp_desc(64'h5_0000_5000); exp_seg(64'h5_0006_0000, 64);
    start_chain(64'h5_0000_5000);
    repeat (12) @(negedge clk);
    reg_write(2'd2, 32'h1);
    finish_chain(0, "R8 restart ignored");
    bp_mode = 0;

    // misaligned segment address in the second descriptor (R10)
    put_desc(64'h6000, 64'h7_0000, 8, 64'h6040);
    put_desc(64'h6040, 64'h7_1002, 8, 64'h0);
    exp_desc(64'h6000); exp_seg(64'h7_0000, 8); exp_desc(64'h6040);
    start_chain(64'h6000);
    finish_chain(1, "R10 misaligned segment");

    // length over the limit (R10)
    bp_mode = 1;
    put_desc(64'h6100, 64'h7_2000, 4, 64'h6140);
    put_desc(64'h6140, 64'h7_3000, 4097, 64'h0);
    exp_desc(64'h6100); exp_seg(64'h7_2000, 4); exp_desc(64'h6140);
    start_chain(64'h6100);
    finish_chain(1, "R10 length 4097");
    bp_mode = 0;

    // misaligned next pointer (R10)
    put_desc(64'h6200, 64'h7_4000, 4, 64'h6241);
    exp_desc(64'h6200); exp_seg(64'h7_4000, 4);
    start_chain(64'h6200);
    finish_chain(1, "R10 misaligned next");

    // misaligned base: no requests at all (R10)
    start_chain(64'h6302);
    finish_chain(1, "R10 misaligned base");

    // boundary length 4096 accepted (R10, R3)
    put_desc(64'h8000, 64'h9_0000, 4096, 64'h0);
    exp_desc(64'h8000); exp_seg(64'h9_0000, 4096);
    start_chain(64'h8000);
    finish_chain(0, "R10 length 4096");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule